// File: doc/BRIEF.md
# Over-Current Pulse-Skip Monitor

This block watches a current-limit flag once per switching period of a buck converter controller. Each switching period begins with a single-clock cycle-start strobe, and the flag is sampled only on that strobe. When the flag is found high in the idle state, the high-side gate is blocked for that switching period and for the eight periods after it. The monitor then opens a confirmation window of eight more period starts. A flag seen again inside the window produces a one-clock fault-trip pulse for an external fault latch. A window that passes without a flag lets the monitor clear itself, and normal switching resumes.

A soft-start mask input marks the early part of start-up. While the mask is high, a flag seen in the window neither trips nor counts as an event. Pulse skipping itself is not masked. The high-side gate is free during the confirmation window, so the converter switches normally while the window is watched.

Top module: `ocp_skip_monitor`

## Requirements
- R1: While reset is low, and after it is released with no strobe yet, `hsInhibit` and `faultTrip` are both 0 and the monitor is idle.
- R2: `limitFlag` has an effect only in a clock where `cycleStart` is 1. A high flag with no strobe leaves both outputs low.
- R3: In the idle state, a strobe with `limitFlag`=1 raises `hsInhibit` from the next clock. It stays high through the next 8 strobes (switching periods 1 to 8 after the event) and falls after the 9th strobe.
- R4: During the skip phase the flag is ignored. A flagged strobe neither lengthens the inhibit nor trips, and this includes the 8th strobe.
- R5: A strobe with `limitFlag`=1 and `ssMask`=0 at any of strobes 9 through 16 after the event raises `faultTrip` in the next clock. The monitor returns to idle with `hsInhibit` low.
- R6: If strobes 9 to 16 pass without an unmasked flag, the monitor goes idle after the 16th strobe. The next flagged strobe then starts a new skip phase instead of tripping.
- R7: A flagged strobe inside the window while `ssMask`=1 produces no trip and counts as no event, and the window runs on to its normal expiry.
- R8: `ssMask`=1 does not prevent a skip phase from starting or running.
- R9: `hsInhibit` is 0 during the confirmation window and in any clock where `faultTrip` is 1.
- R10: `faultTrip` is high for exactly one clock per trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleStart | input | 1 | One-clock strobe marking the start of a switching period |
| limitFlag | input | 1 | Current-limit flag, sampled on the strobe |
| ssMask | input | 1 | High while soft-start is below its trip-enable level; blocks trips |
| hsInhibit | output | 1 | High blocks the high-side gate drive |
| faultTrip | output | 1 | One-clock pulse that sets the external fault latch |

## Verification
The window has two edge strobes where two decisions fall on the same strobe. On the 9th strobe, the end of skipping coincides with the first window sample. On the 16th strobe, window expiry competes with a trip. The bench places a flagged strobe on each of those edges and expects a trip with the inhibit already low. It also places a masked flag on the 16th strobe and expects silent expiry, which it confirms by the next flagged strobe restarting a skip phase instead of tripping.

// File: rtl/ocp_skip_pkg.sv
package ocp_skip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_WATCH = 2'd2
  } ocpState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;
    logic incCnt;
    logic setTrip;
  } ctlStrobe_t;

  // counter decodes from datapath back to control
  typedef struct packed {
    logic atSkipEnd;
    logic atWindowEnd;
  } cntStatus_t;

endpackage

// File: rtl/ocp_skip_datapath.sv
module ocp_skip_datapath
  import ocp_skip_pkg::*;
#(
  parameter int SKIP_CYCLES  = 8,
  parameter int WATCH_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output cntStatus_t sts,
  output logic       tripPulse
);

  localparam int TOTAL = SKIP_CYCLES + WATCH_CYCLES;
  localparam int CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam logic [CNT_W-1:0] SKIP_END = CNT_W'(SKIP_CYCLES);
  localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] cycCnt;
  logic             tripReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt  <= '0;
      tripReg <= 1'b0;
    end else begin
      tripReg <= ctl.setTrip;
      if (ctl.clearCnt) begin
        cycCnt <= '0;
      end else if (ctl.incCnt) begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

  always_comb begin
    sts.atSkipEnd   = (cycCnt == SKIP_END);
    sts.atWindowEnd = (cycCnt == WIN_END);
  end

  assign tripPulse = tripReg;

  // R10: a trip pulse never lasts two clocks
  assert_trip_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    tripReg |=> !tripReg);

  // R6: one step per strobe, never wrapping past the window end
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incCnt && !ctl.clearCnt |=> cycCnt == $past(cycCnt) + 1'b1);

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    cycCnt <= WIN_END);

endmodule

// File: rtl/ocp_skip_control.sv
module ocp_skip_control
  import ocp_skip_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStart,
  input  logic       limitFlag,
  input  logic       ssMask,
  input  cntStatus_t sts,
  output ctlStrobe_t ctl,
  output logic       hsInhibit
);

  ocpState_t state;
  ocpState_t nextState;
  logic      windowHit;

  assign windowHit = limitFlag && !ssMask;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (cycleStart && limitFlag) begin
          nextState    = ST_SKIP;
          ctl.clearCnt = 1'b1;
        end
      end
      ST_SKIP: begin
        if (cycleStart) begin
          if (!sts.atSkipEnd) begin
            ctl.incCnt = 1'b1;
          end else if (windowHit) begin
            ctl.setTrip = 1'b1;
            nextState   = ST_IDLE;
          end else if (sts.atWindowEnd) begin
            nextState = ST_IDLE;
          end else begin
            ctl.incCnt = 1'b1;
            nextState  = ST_WATCH;
          end
        end
      end
      ST_WATCH: begin
        if (cycleStart) begin
          if (windowHit) begin
            ctl.setTrip = 1'b1;
            nextState   = ST_IDLE;
          end else if (sts.atWindowEnd) begin
            nextState = ST_IDLE;
          end else begin
            ctl.incCnt = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  assign hsInhibit = (state == ST_SKIP);

  // R3: a flagged strobe in idle starts skipping on the next clock
  assert_skip_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && cycleStart && limitFlag |=> hsInhibit);

  // R2: without a strobe the state never moves
  assert_no_strobe_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStart |=> $stable(state));

  // R7: a trip is never requested while the mask is up
  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setTrip |-> !ssMask && cycleStart);

  // R9: the window never blocks the high side
  assert_watch_free_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WATCH) |-> !hsInhibit);

endmodule

// File: rtl/ocp_skip_monitor.sv
module ocp_skip_monitor
  import ocp_skip_pkg::*;
#(
  parameter int SKIP_CYCLES  = 8,
  parameter int WATCH_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleStart,
  input  logic limitFlag,
  input  logic ssMask,
  output logic hsInhibit,
  output logic faultTrip
);

  ctlStrobe_t ctl;
  cntStatus_t sts;

  ocp_skip_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .limitFlag  (limitFlag),
    .ssMask     (ssMask),
    .sts        (sts),
    .ctl        (ctl),
    .hsInhibit  (hsInhibit)
  );

  ocp_skip_datapath #(
    .SKIP_CYCLES  (SKIP_CYCLES),
    .WATCH_CYCLES (WATCH_CYCLES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sts       (sts),
    .tripPulse (faultTrip)
  );

  // R9 / R5: a trip always leaves the gate free
  assert_trip_no_inhibit_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultTrip |-> !hsInhibit);

endmodule

// File: tb/test_ocp_skip_monitor.sv
module test_ocp_skip_monitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStart = 1'b0;
  logic limitFlag = 1'b0;
  logic ssMask = 1'b0;
  logic hsInhibit;
  logic faultTrip;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ocp_skip_monitor i_ocp_skip_monitor (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .limitFlag  (limitFlag),
    .ssMask     (ssMask),
    .hsInhibit  (hsInhibit),
    .faultTrip  (faultTrip)
  );

  // each entry: {flag, mask, expected inhibit, expected trip}
  localparam int NVEC = 30;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0000,                                  // idle strobe, no flag (R2)
    4'b1010,                                  // event (R3)
    4'b0010, 4'b1010, 4'b0010, 4'b1010,       // skip 1..4, flags ignored (R4)
    4'b0010, 4'b1010, 4'b0010, 4'b1010,       // skip 5..8, flag at 8th (R4)
    4'b0000,                                  // strobe 9: window opens (R9)
    4'b0000, 4'b0000, 4'b0100,                // strobes 10..12
    4'b0000, 4'b1100, 4'b0000,                // 13..15, masked flag at 14 (R7)
    4'b1001,                                  // strobe 16 trips (R5)
    4'b0000,                                  // back in idle
    4'b1010,                                  // new event
    4'b0010, 4'b0010, 4'b0010, 4'b0010,
    4'b0010, 4'b0010, 4'b0010, 4'b0010,       // skip 1..8
    4'b1001,                                  // strobe 9 trips (R5)
    4'b0000
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one strobe, then sample at the following falling edge
  task automatic strobe(input logic f, input logic m);
    @(negedge clk);
    cycleStart = 1'b1;
    limitFlag  = f;
    ssMask     = m;
    @(negedge clk);
    cycleStart = 1'b0;
    limitFlag  = 1'b0;
    ssMask     = 1'b0;
  endtask

  task automatic gap();
    @(negedge clk);
    check("R10 trip width", faultTrip, 1'b0);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 inhibit in reset", hsInhibit, 1'b0);
    check("R1 trip in reset", faultTrip, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 inhibit after reset", hsInhibit, 1'b0);
    check("R1 trip after reset", faultTrip, 1'b0);

    // R2: flag without strobe
    limitFlag = 1'b1;
    repeat (4) @(negedge clk);
    limitFlag = 1'b0;
    @(negedge clk);
    check("R2 flag w/o strobe inhibit", hsInhibit, 1'b0);
    check("R2 flag w/o strobe trip", faultTrip, 1'b0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      strobe(VEC[i][3], VEC[i][2]);
      check($sformatf("R3/R4/R5/R9 vec %0d inhibit", i), hsInhibit, VEC[i][1]);
      check($sformatf("R5/R7 vec %0d trip", i), faultTrip, VEC[i][0]);
      gap();
    end

    // R8 + R7: skip under mask, window fully masked, then expiry (R6)
    strobe(1'b1, 1'b1);
    check("R8 masked event inhibit", hsInhibit, 1'b1);
    gap();
    for (int k = 1; k <= 8; k++) begin
      strobe(1'b0, 1'b1);
      gap();
    end
    check("R8 inhibit through skip", hsInhibit, 1'b1);
    for (int k = 9; k <= 16; k++) begin
      strobe(1'b1, 1'b1);
      check("R7 masked window trip", faultTrip, 1'b0);
      check("R9 window inhibit", hsInhibit, 1'b0);
      gap();
    end
    // expired: a flagged strobe starts skipping rather than tripping
    strobe(1'b1, 1'b0);
    check("R6 restart after expiry trip", faultTrip, 1'b0);
    check("R6 restart after expiry inhibit", hsInhibit, 1'b1);
    gap();

    // R6: quiet window recovery, then a fresh event
    for (int k = 1; k <= 8; k++) begin
      strobe(1'b0, 1'b0);
      gap();
    end
    check("R3 inhibit falls only after 9th strobe", hsInhibit, 1'b1);
    strobe(1'b0, 1'b0);
    check("R3 inhibit falls at 9th strobe", hsInhibit, 1'b0);
    gap();
    for (int k = 10; k <= 16; k++) begin
      strobe(1'b0, 1'b0);
      gap();
    end
    strobe(1'b1, 1'b0);
    check("R6 quiet window recover trip", faultTrip, 1'b0);
    check("R6 quiet window recover inhibit", hsInhibit, 1'b1);
    gap();

    // R1: reset in mid-skip clears the inhibit
    strobe(1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset mid-skip inhibit", hsInhibit, 1'b0);
    check("R1 reset mid-skip trip", faultTrip, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    strobe(1'b0, 1'b0);
    check("R1 idle after mid-skip reset", hsInhibit, 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule